// File: doc/BRIEF.md
# CAN Error and Status Register

This block is the 32-bit error and status word that a CAN controller exposes to its host processor. It gathers single-cycle event strobes from the protocol engine (frame sent, frame received, message-RAM parity fault, bus activity while powered down, and a new last-error code) together with level states (bus-off, error-passive, power-down acknowledge and the two error counters). It presents them as one word on a read port.

The event flags are sticky and clear when the word is read. The last-error-code field returns to its "unchanged" value 7 when the word is read. Whenever a hardware event meets a read in the same cycle, the event wins, so no event is ever lost. The read port shows the word as it was before the read. The side effects of a read take effect on the clock edge that ends the read strobe. The warning bit is not stored: it is computed from the two error counters against a threshold of 96.

Top module: `can_err_status`

## Requirements
- R1: Bits 31 to 11 of `rd_data` always read 0.
- R2: Bit 10 of `rd_data` equals `pd_ack` in the same cycle.
- R3: Bit 9 (wake pending) sets when `bus_dominant` is high while `pd_ack` is high. It clears on a read. `bus_dominant` while `pd_ack` is low has no effect.
- R4: Bit 8 (parity error) sets on `parity_evt` and clears on a read.
- R5: Bit 7 follows `bus_off` and bit 5 follows `err_passive`, both in the same cycle.
- R6: Bit 6 is 1 when `tx_err_cnt` >= 96 or `rx_err_cnt` >= 96, and 0 when both are below 96.
- R7: Bit 4 (receive OK) sets on `rx_ok_evt` and bit 3 (transmit OK) sets on `tx_ok_evt`. Both clear on a read.
- R8: Bits 2 to 0 hold the last error code. The code is 7 after reset, it loads `lec_val` when `lec_wr` is high, and it returns to 7 after a read. Code 7 means "no change since last read".
- R9: When a set event and a read occur in the same cycle, the flag is 1 after that cycle.
- R10: When `lec_wr` and a read occur in the same cycle, the field holds `lec_val` afterwards, not 7.
- R11: During a read cycle, `rd_data` shows the value held before the read. The clears and the reload of 7 are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe, one cycle per read access |
| tx_ok_evt | input | 1 | Frame transmitted successfully |
| rx_ok_evt | input | 1 | Frame received successfully |
| parity_evt | input | 1 | Message-RAM parity error detected |
| bus_dominant | input | 1 | Dominant level seen on the bus |
| pd_ack | input | 1 | Module is in local power-down |
| lec_wr | input | 1 | Load a new last-error code |
| lec_val | input | 3 | Last-error code to load |
| bus_off | input | 1 | Bus-off state |
| err_passive | input | 1 | Error-passive state |
| tx_err_cnt | input | 8 | Transmit error counter |
| rx_err_cnt | input | 8 | Receive error counter |
| rd_data | output | 32 | Status word |

## Verification
The hardest situations to reach are the collisions: a set event in the very cycle a read clears the same flag, and a fresh error code arriving in the cycle a read would reload 7. The stimulus vectors hold the read strobe high while these events pulse. For each such cycle the bench samples `rd_data` twice: once before the edge, to see the pre-read value, and once after the edge, to see that the event survived. The wake flag also depends on a level that must be held during power-down, so the vectors raise `pd_ack` together with `bus_dominant`. They also drive `bus_dominant` alone, to show that it is ignored.

// File: rtl/err_status_pkg.sv
package err_status_pkg;

    localparam int unsigned BIT_PDA    = 10;
    localparam int unsigned BIT_WAKE   = 9;
    localparam int unsigned BIT_PAR    = 8;
    localparam int unsigned BIT_BOFF   = 7;
    localparam int unsigned BIT_WARN   = 6;
    localparam int unsigned BIT_EPASS  = 5;
    localparam int unsigned BIT_RXOK   = 4;
    localparam int unsigned BIT_TXOK   = 3;
    localparam int unsigned LEC_W      = 3;
    localparam int unsigned USED_W     = 11;
    localparam int unsigned NUM_STICKY = 4;

    typedef enum logic [LEC_W-1:0] {
        LEC_NONE  = 3'd0,
        LEC_STUFF = 3'd1,
        LEC_FORM  = 3'd2,
        LEC_ACK   = 3'd3,
        LEC_BIT1  = 3'd4,
        LEC_BIT0  = 3'd5,
        LEC_CRC   = 3'd6,
        LEC_NOCHG = 3'd7
    } lec_code_e;

endpackage

// File: rtl/esr_sticky_bit.sv
module esr_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    logic q_next;

    // Setting takes precedence over clearing.
    always_comb begin
        q_next = q_o;
        if (clr_i) q_next = 1'b0;
        if (set_i) q_next = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= q_next;
    end

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/esr_lec_field.sv
module esr_lec_field
    import err_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic [LEC_W-1:0] val_i,
    output logic [LEC_W-1:0] code_o
);

    lec_code_e code_q, code_d;

    // A load from the protocol engine overrides the reload caused by a read.
    always_comb begin
        code_d = code_q;
        unique case ({wr_i, rd_i})
            2'b00: code_d = code_q;
            2'b01: code_d = LEC_NOCHG;
            2'b10,
            2'b11: code_d = lec_code_e'(val_i);
            default: code_d = code_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= LEC_NOCHG;
        else        code_q <= code_d;
    end

    assign code_o = code_q;

    a_r8_read_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !wr_i) |=> (code_o == 3'd7));
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (code_o == $past(val_i)));

endmodule

// File: rtl/esr_warn_cmp.sv
module esr_warn_cmp #(
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned WARN_LIMIT = 96
) (
    input  logic [CNT_W-1:0] tx_cnt_i,
    input  logic [CNT_W-1:0] rx_cnt_i,
    output logic             warn_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WARN_LIMIT);

    assign warn_o = (tx_cnt_i >= LIMIT) || (rx_cnt_i >= LIMIT);

endmodule

// File: rtl/can_err_status.sv
module can_err_status
    import err_status_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned WARN_LIMIT = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              tx_ok_evt,
    input  logic              rx_ok_evt,
    input  logic              parity_evt,
    input  logic              bus_dominant,
    input  logic              pd_ack,
    input  logic              lec_wr,
    input  logic [LEC_W-1:0]  lec_val,
    input  logic              bus_off,
    input  logic              err_passive,
    input  logic [CNT_W-1:0]  tx_err_cnt,
    input  logic [CNT_W-1:0]  rx_err_cnt,
    output logic [DATA_W-1:0] rd_data
);

    // Sticky flag index order: 0 tx ok, 1 rx ok, 2 parity, 3 wake.
    logic [NUM_STICKY-1:0] st_set;
    logic [NUM_STICKY-1:0] st_q;
    logic                  warn;
    logic [LEC_W-1:0]      lec_q;

    assign st_set = {bus_dominant & pd_ack, parity_evt, rx_ok_evt, tx_ok_evt};

    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
        esr_sticky_bit u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (st_set[i]),
            .clr_i (rd_en),
            .q_o   (st_q[i])
        );
    end

    esr_lec_field u_lec (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_i   (rd_en),
        .wr_i   (lec_wr),
        .val_i  (lec_val),
        .code_o (lec_q)
    );

    esr_warn_cmp #(.CNT_W(CNT_W), .WARN_LIMIT(WARN_LIMIT)) u_warn (
        .tx_cnt_i (tx_err_cnt),
        .rx_cnt_i (rx_err_cnt),
        .warn_o   (warn)
    );

    // The word is formed from the stored values, so a read returns them before any clear.
    always_comb begin
        rd_data            = '0;
        rd_data[BIT_PDA]   = pd_ack;
        rd_data[BIT_WAKE]  = st_q[3];
        rd_data[BIT_PAR]   = st_q[2];
        rd_data[BIT_BOFF]  = bus_off;
        rd_data[BIT_WARN]  = warn;
        rd_data[BIT_EPASS] = err_passive;
        rd_data[BIT_RXOK]  = st_q[1];
        rd_data[BIT_TXOK]  = st_q[0];
        rd_data[LEC_W-1:0] = lec_q;
    end

    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:USED_W] == '0);
    a_r3_wake_ignored_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_ack && !rd_en && !rd_data[BIT_WAKE]) |=> !rd_data[BIT_WAKE]);
    a_r11_read_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && rd_data[BIT_TXOK]) |=> rd_data[BIT_TXOK]);

endmodule

// File: tb/sim_can_err_status.sv
module sim_can_err_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, tx_ok_evt = 1'b0, rx_ok_evt = 1'b0, parity_evt = 1'b0;
    logic        bus_dominant = 1'b0, pd_ack = 1'b0, lec_wr = 1'b0;
    logic [2:0]  lec_val = 3'd0;
    logic        bus_off = 1'b0, err_passive = 1'b0;
    logic [7:0]  tx_err_cnt = 8'd0, rx_err_cnt = 8'd0;
    logic [31:0] rd_data;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    can_err_status u0 (.*);

    typedef struct packed {
        logic       rd, tx, rx, par, dom, pd, wr;
        logic [2:0] val;
        logic       boff, epass;
        logic [7:0] tec, rec;
        logic [10:0] pre, post;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,8'd0, 8'd0, 11'h007,11'h007},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,3'd3,1'b0,1'b0,8'd0, 8'd0, 11'h007,11'h00B},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,8'd96,8'd0, 11'h04B,11'h05B},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,8'd95,8'd96,11'h05B,11'h047},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,1'b1,1'b1,8'd0, 8'd95,11'h0A7,11'h1A7},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,3'd0,1'b0,1'b0,8'd0, 8'd0, 11'h507,11'h607},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,3'd5,1'b0,1'b0,8'd0, 8'd0, 11'h607,11'h415},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,8'd0, 8'd0, 11'h015,11'h015},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,8'd0, 8'd0, 11'h015,11'h007}
    };

    string vtag [NV] = '{
        "R8 reset idle",
        "R7 tx set, R8 code load",
        "R6 warn on tx count, R7 rx set",
        "R11 pre-read value, R6 warn on rx count, R7 R8 read effects",
        "R4 parity set, R5 bus-off and passive",
        "R2 power-down, R3 wake set vs read, R9 collision",
        "R3 wake clear, R9 rx set wins, R10 code load wins",
        "R3 dominant ignored when awake",
        "R11 read clears rx, R8 reload"
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        rd_en = v.rd; tx_ok_evt = v.tx; rx_ok_evt = v.rx; parity_evt = v.par;
        bus_dominant = v.dom; pd_ack = v.pd; lec_wr = v.wr; lec_val = v.val;
        bus_off = v.boff; err_passive = v.epass; tx_err_cnt = v.tec; rx_err_cnt = v.rec;
    endtask

    initial begin : watchdog
        #2000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check("R8 reset value", rd_data, 32'h0000_0007);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            #1;
            check({vtag[i], " (before edge)"}, rd_data, {21'd0, VEC[i].pre});
            @(posedge clk);
            #1;
            check({vtag[i], " (after edge)"}, rd_data, {21'd0, VEC[i].post});
            check("R1 upper bits zero", {21'd0, rd_data[31:11]}, 32'd0);
        end

        // R6 threshold corner: both counters at 95
        @(negedge clk);
        apply('0);
        tx_err_cnt = 8'd95; rx_err_cnt = 8'd95;
        #1;
        check("R6 both below limit", {31'd0, rd_data[6]}, 32'd0);
        rx_err_cnt = 8'd255;
        #1;
        check("R6 counter at max", {31'd0, rd_data[6]}, 32'd1);

        // R4 parity set while reading survives, then a read alone clears it
        @(negedge clk);
        apply('0);
        parity_evt = 1'b1; rd_en = 1'b1;
        @(posedge clk); #1;
        check("R4 R9 parity set during read", {31'd0, rd_data[8]}, 32'd1);
        @(negedge clk);
        parity_evt = 1'b0;
        @(posedge clk); #1;
        check("R4 parity cleared by read", {31'd0, rd_data[8]}, 32'd0);

        // Reset in the middle of activity
        @(negedge clk);
        apply('0);
        tx_ok_evt = 1'b1; lec_wr = 1'b1; lec_val = 3'd2;
        @(posedge clk); #1;
        check("R7 R8 before reset", rd_data, 32'h0000_000A);
        @(negedge clk);
        apply('0);
        rst_n = 1'b0;
        #1;
        check("R8 reset clears flags and reloads code", rd_data, 32'h0000_0007);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule